// File: doc/BRIEF.md
# Microcode Region Lock Controller

This block guards an 8 KB dual-port RAM that is shared between a host bus and a communications processor. Part of the RAM can be set aside for the processor's executable microcode. A 2-bit size select picks how much of the low end of the RAM is reserved, and with it a small extension region. A one-bit high-region enable, held in an 8-bit control register, also reserves a 2 KB block in the upper half of the RAM together with its own 512-byte extension.

When the host reads a reserved location, it gets all ones back instead of the stored word. Host writes to reserved locations are dropped. The processor port reads and writes every location without restriction. A combinational flag reports whether the processor's current address falls inside the reserved set, which is the set of legal microcode fetch locations.

The top 1 KB holds parameters and is never reserved. Both RAM ports are 32 bits wide and word addressed. Both return read data one cycle after the request.

Top module: `mrl_lock_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00 and the high region is not reserved.
- R2: The control register is selected when `reg_addr` is 0x9C7. A write stores only `reg_wdata[7]`, the high-region enable, which is bit 0 in MSB-first numbering. Bits 6:0 always read as zero. Writes to any other address leave the register unchanged, and a read at any other address returns 0x00.
- R3: `cfg_size` reserves the low microcode area starting at byte 0x0000. The encoding 00 reserves nothing, 01 reserves bytes below 0x0200, 10 reserves bytes below 0x0400, and 11 reserves bytes below 0x0800.
- R4: The extension region starts at byte 0x0E00. It is 256 bytes (0x0E00–0x0EFF) when `cfg_size` is 01 or 10, 512 bytes (0x0E00–0x0FFF) when it is 11, and absent when it is 00.
- R5: While the high-region enable is set, bytes 0x1000–0x19FF are reserved. This is the 2 KB block plus its 512-byte extension.
- R6: A host read of a reserved word returns 0xFFFFFFFF on `host_rdata` one cycle after the request.
- R7: A host write to a reserved word leaves the stored word unchanged.
- R8: The processor port reads and writes every word, reserved or not. Its read data appears one cycle after the request.
- R9: Words that are not reserved, including the parameter area 0x1C00–0x1FFF, are read and written normally by the host.
- R10: `cp_fetch_ok` is high exactly when `cp_addr` lies in the reserved set, under the current size select and high-region enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_size | input | 2 | Low microcode area size select, from the neighbouring configuration register |
| reg_addr | input | 12 | Register-area offset for the control register |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data (combinational) |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 11 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, all ones for reserved words |
| cp_en | input | 1 | Processor access request |
| cp_we | input | 1 | Processor write (1) or read (0) |
| cp_addr | input | 11 | Processor word address |
| cp_wdata | input | 32 | Processor write data |
| cp_rdata | output | 32 | Processor read data |
| cp_fetch_ok | output | 1 | Processor address is a legal microcode location |

## Verification
The bench probes the last word below and the first word above every region edge (0x01FC/0x0200, 0x03FC/0x0400, 0x07FC/0x0800, 0x0DFC/0x0E00, 0x0EFC/0x0F00, 0x0FFC/0x1000, 0x19FC/0x1A00, 0x1BFC/0x1C00). It does this for all eight combinations of size select and high enable. An off-by-one bound would show up as real data where all ones belong, or the reverse. Confusing the 256-byte and 512-byte extension lengths would expose or hide 0x0F00–0x0FFF. After each dropped host write, the bench reads the same word back through the processor port. A design that masks only reads would show the host's pattern there. Junk in the reserved control bits and writes to the neighbouring offset 0x9C6 catch a register that stores too much or decodes too loosely.

// File: rtl/mrl_pkg.sv
// Shared constants and types for the microcode region lock controller.
// Assumes an 8 KB RAM; all region bounds are byte offsets from the RAM base.
package mrl_pkg;
    localparam int unsigned LOW_BLK_BYTES = 512;
    localparam int unsigned EXT_BASE      = 32'h0E00;
    localparam int unsigned EXT_SHORT     = 256;
    localparam int unsigned EXT_LONG      = 512;
    localparam int unsigned HI_BASE       = 32'h1000;
    localparam int unsigned HI_BYTES      = 2048;
    localparam int unsigned HI_EXT_BYTES  = 512;
    localparam int unsigned PARAM_BASE    = 32'h1C00;

    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_ONE  = 2'b01,
        SZ_TWO  = 2'b10,
        SZ_FOUR = 2'b11
    } ucode_size_e;
endpackage

// File: rtl/mrl_region_decode.sv
// Region decoder: says whether a word address lies in the reserved microcode set.
// Assumes word addressing with 2**OFF_W bytes per word; purely combinational.
module mrl_region_decode
    import mrl_pkg::*;
#(
    parameter int AW    = 11,
    parameter int OFF_W = 2
) (
    input  logic [AW-1:0] word_addr,
    input  logic [1:0]    size_sel,
    input  logic          hi_en,
    output logic          locked
);
    localparam int BA_W = AW + OFF_W;

    logic [BA_W-1:0] byte_addr;
    logic [31:0]     ba;
    logic [31:0]     low_top;
    logic [31:0]     ext_len;
    logic            low_hit, ext_hit, hi_hit;

    assign byte_addr = {word_addr, {OFF_W{1'b0}}};
    assign ba        = 32'(byte_addr);

    // Region sizes selected by the size field
    always_comb begin
        unique case (ucode_size_e'(size_sel))
            SZ_NONE: begin low_top = 32'd0;                 ext_len = 32'd0;       end
            SZ_ONE:  begin low_top = LOW_BLK_BYTES;         ext_len = EXT_SHORT;   end
            SZ_TWO:  begin low_top = 2 * LOW_BLK_BYTES;     ext_len = EXT_SHORT;   end
            default: begin low_top = 4 * LOW_BLK_BYTES;     ext_len = EXT_LONG;    end
        endcase
    end

    // Membership tests for each of the three regions
    always_comb begin
        low_hit = ba < low_top;
        ext_hit = (ba >= EXT_BASE) && (ba < EXT_BASE + ext_len);
        hi_hit  = hi_en && (ba >= HI_BASE) && (ba < HI_BASE + HI_BYTES + HI_EXT_BYTES);
        locked  = low_hit || ext_hit || hi_hit;
    end
endmodule

// File: rtl/mrl_ctrl_reg.sv
// 8-bit control register holding the high-region enable.
// Assumes one register offset; only the MSB (MSB-first bit 0) is implemented.
module mrl_ctrl_reg #(
    parameter int              REG_AW      = 12,
    parameter logic [REG_AW-1:0] REG_OFFSET = 12'h9C7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              hi_en
);
    localparam int HI_BIT = 7;

    logic hit;
    assign hit = (reg_addr == REG_OFFSET);

    // Enable flop: cleared by reset, loaded on a selected write
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_en <= 1'b0;
        else if (reg_we && hit)
            hi_en <= reg_wdata[HI_BIT];
    end

    // Read mux: reserved bits return zero
    always_comb begin
        reg_rdata = 8'h00;
        if (hit)
            reg_rdata[HI_BIT] = hi_en;
    end
endmodule

// File: rtl/mrl_dpram.sv
// Behavioural dual-port RAM, one registered read per port.
// Assumes callers avoid same-word writes from both ports; port B wins if not.
module mrl_dpram #(
    parameter int DW = 32,
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Array writes from both ports
    always_ff @(posedge clk) begin
        if (a_en && a_we) mem[a_addr] <= a_wdata;
        if (b_en && b_we) mem[b_addr] <= b_wdata;
    end

    // Registered reads, held between requests
    always_ff @(posedge clk) begin
        if (a_en && !a_we) a_rdata <= mem[a_addr];
        if (b_en && !b_we) b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/mrl_lock_ctrl.sv
// Top: reserves microcode regions of a shared RAM, masks host reads of them
// to all ones, drops host writes to them and flags legal processor fetches.
// Assumes the size select is supplied stable from a neighbouring register.
module mrl_lock_ctrl #(
    parameter int                DATA_W      = 32,
    parameter int                RAM_BYTES   = 8192,
    parameter int                REG_AW      = 12,
    parameter logic [REG_AW-1:0] CTRL_OFFSET = 12'h9C7,
    localparam int               OFF_W       = $clog2(DATA_W / 8),
    localparam int               AW          = $clog2(RAM_BYTES) - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_size,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cp_en,
    input  logic              cp_we,
    input  logic [AW-1:0]     cp_addr,
    input  logic [DATA_W-1:0] cp_wdata,
    output logic [DATA_W-1:0] cp_rdata,
    output logic              cp_fetch_ok
);
    logic              hi_en;
    logic              host_lock;
    logic              host_lock_q;
    logic [DATA_W-1:0] ram_host_rdata;

    mrl_ctrl_reg #(.REG_AW(REG_AW), .REG_OFFSET(CTRL_OFFSET)) u_reg (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hi_en(hi_en)
    );

    mrl_region_decode #(.AW(AW), .OFF_W(OFF_W)) u_dec_host (
        .word_addr(host_addr), .size_sel(cfg_size), .hi_en(hi_en), .locked(host_lock)
    );

    mrl_region_decode #(.AW(AW), .OFF_W(OFF_W)) u_dec_cp (
        .word_addr(cp_addr), .size_sel(cfg_size), .hi_en(hi_en), .locked(cp_fetch_ok)
    );

    mrl_dpram #(.DW(DATA_W), .AW(AW)) u_ram (
        .clk(clk),
        .a_en(host_en), .a_we(host_we && !host_lock), .a_addr(host_addr),
        .a_wdata(host_wdata), .a_rdata(ram_host_rdata),
        .b_en(cp_en), .b_we(cp_we), .b_addr(cp_addr),
        .b_wdata(cp_wdata), .b_rdata(cp_rdata)
    );

    // Remember whether the last host read targeted a reserved word
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_lock_q <= 1'b0;
        else if (host_en && !host_we)
            host_lock_q <= host_lock;
    end

    assign host_rdata = host_lock_q ? {DATA_W{1'b1}} : ram_host_rdata;
endmodule

// File: rtl/mrl_lock_chk.sv
// Checker for the lock controller, bound into every instance of the top.
module mrl_lock_chk #(
    parameter int AW     = 11,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_size,
    input logic              hi_en,
    input logic              host_en,
    input logic              host_we,
    input logic [AW-1:0]     host_addr,
    input logic              host_lock,
    input logic [DATA_W-1:0] host_rdata,
    input logic [AW-1:0]     cp_addr,
    input logic              cp_fetch_ok,
    input logic [7:0]        reg_rdata
);
    logic [31:0] hba;
    assign hba = 32'({host_addr, {OFF_W{1'b0}}});

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !hi_en);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:0] == 7'd0);

    // R3
    no_low_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size == 2'b00 && hba < 32'h0E00) |-> !host_lock);

    // R5
    high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_en && hba >= 32'h1000 && hba < 32'h1A00) |-> !host_lock);

    // R6
    locked_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_en && !host_we && host_lock) |=> host_rdata == {DATA_W{1'b1}});

    // R9
    param_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hba >= 32'h1C00 |-> !host_lock);

    // R10
    fetch_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_addr == host_addr) |-> cp_fetch_ok == host_lock);
endmodule

bind mrl_lock_ctrl mrl_lock_chk #(.AW(AW), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .hi_en(hi_en),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_lock(host_lock), .host_rdata(host_rdata), .cp_addr(cp_addr),
    .cp_fetch_ok(cp_fetch_ok), .reg_rdata(reg_rdata)
);

// File: tb/tb_mrl_lock_ctrl.sv
module tb_mrl_lock_ctrl;
    localparam int PERIOD = 10;
    localparam int WORDS  = 2048;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_size;
    logic [11:0] reg_addr;
    logic        reg_we;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        host_en, host_we, cp_en, cp_we;
    logic [10:0] host_addr, cp_addr;
    logic [31:0] host_wdata, host_rdata, cp_wdata, cp_rdata;
    logic        cp_fetch_ok;

    int checks = 0;
    int fails  = 0;
    logic [31:0] ref_mem [WORDS];
    int  cur_sz;
    bit  cur_hi;
    bit  finished = 0;

    always #(PERIOD/2) clk = ~clk;

    mrl_lock_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cp_en(cp_en), .cp_we(cp_we), .cp_addr(cp_addr),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_fetch_ok(cp_fetch_ok)
    );

    // Reference: reserved-set membership straight from the requirements
    function automatic bit ref_lock(int unsigned ba, int sz, bit hi);
        if (sz == 1 && ba < 'h200) return 1;                     // R3
        if (sz == 2 && ba < 'h400) return 1;
        if (sz == 3 && ba < 'h800) return 1;
        if ((sz == 1 || sz == 2) && ba >= 'hE00 && ba < 'hF00) return 1;  // R4
        if (sz == 3 && ba >= 'hE00 && ba < 'h1000) return 1;
        if (hi && ba >= 'h1000 && ba < 'h1A00) return 1;         // R5
        return 0;
    endfunction

    function automatic string tag_of(int unsigned ba);
        if (ba < 'h800) return "R3";
        if (ba >= 'hE00 && ba < 'h1000) return "R4";
        if (ba >= 'h1000 && ba < 'h1A00) return "R5";
        return "R9";
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle on both ports; starts and ends just after a falling edge
    task automatic bus(bit h_en, bit h_we, int h_a, logic [31:0] h_d,
                       bit c_en, bit c_we, int c_a, logic [31:0] c_d);
        logic [31:0] exp_h, exp_c;
        bit          hl;
        host_en = h_en; host_we = h_we; host_addr = 11'(h_a); host_wdata = h_d;
        cp_en = c_en; cp_we = c_we; cp_addr = 11'(c_a); cp_wdata = c_d;
        #1;
        check32("R10", 32'(cp_fetch_ok), 32'(ref_lock(c_a * 4, cur_sz, cur_hi)));
        hl    = ref_lock(h_a * 4, cur_sz, cur_hi);
        exp_h = hl ? 32'hFFFF_FFFF : ref_mem[h_a];
        exp_c = ref_mem[c_a];
        if (h_en && h_we && !hl) ref_mem[h_a] = h_d;   // R7: locked writes dropped
        if (c_en && c_we) ref_mem[c_a] = c_d;          // R8: always allowed
        @(posedge clk);
        @(negedge clk);
        host_en = 0; cp_en = 0;
        if (h_en && !h_we)
            check32(hl ? "R6" : tag_of(h_a * 4), host_rdata, exp_h);
        if (c_en && !c_we)
            check32("R8", cp_rdata, exp_c);
    endtask

    task automatic reg_write(int a, logic [7:0] d);
        reg_addr = 12'(a); reg_we = 1; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 0;
        if (a == 'h9C7) cur_hi = d[7];
    endtask

    task automatic reg_check(string req, int a, logic [7:0] exp);
        reg_addr = 12'(a);
        #1;
        check32(req, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic set_cfg(int sz, bit hi);
        cfg_size = 2'(sz);
        cur_sz = sz;
        reg_write('h9C7, {hi, 7'h5A});                  // reserved bits junk
        reg_check("R2", 'h9C7, {hi, 7'h00});
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int probes [19] = '{'h000, 'h1FC, 'h200, 'h3FC, 'h400, 'h7FC, 'h800,
                            'hDFC, 'hE00, 'hEFC, 'hF00, 'hFFC, 'h1000, 'h17FC,
                            'h19FC, 'h1A00, 'h1BFC, 'h1C00, 'h1FFC};
        rst_n = 0; cfg_size = 0; reg_addr = 0; reg_we = 0; reg_wdata = 0;
        host_en = 0; host_we = 0; host_addr = 0; host_wdata = 0;
        cp_en = 0; cp_we = 0; cp_addr = 0; cp_wdata = 0;
        cur_sz = 0; cur_hi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        reg_check("R1", 'h9C7, 8'h00);
        cp_addr = 11'h400; #1;
        check32("R1", 32'(cp_fetch_ok), 32'd0);

        // preload through the processor port
        for (int i = 0; i < WORDS; i++)
            bus(0, 0, 0, 0, 1, 1, i, 32'hC0DE_0000 ^ (i * 32'h0001_0101));

        // R2: neighbouring offset must not hit the register
        reg_write('h9C6, 8'hFF);
        reg_check("R2", 'h9C7, 8'h00);
        reg_check("R2", 'h9C6, 8'h00);

        // Boundary sweep over every configuration
        for (int sz = 0; sz < 4; sz++) begin
            for (int hi = 0; hi < 2; hi++) begin
                set_cfg(sz, hi[0]);
                for (int p = 0; p < 19; p++) begin
                    int w = probes[p] / 4;
                    bus(1, 1, w, 32'h5EED_0000 + 32'(p * 16 + sz * 4 + hi), 0, 0, 0, 0);
                    bus(1, 0, w, 0, 1, 0, w, 0);   // R7 seen on the processor read
                    bus(0, 0, 0, 0, 1, 1, w, 32'hBEEF_0000 + 32'(p));
                    bus(1, 0, w, 0, 1, 0, (w + 1) % WORDS, 0);
                end
            end
        end

        // Random traffic with occasional reconfiguration
        for (int n = 0; n < 4000; n++) begin
            int ha = $urandom_range(WORDS - 1);
            int ca = $urandom_range(WORDS - 1);
            bit hw = $urandom_range(1);
            bit cw = $urandom_range(3) == 0;
            if (n % 500 == 0) set_cfg($urandom_range(3), 1'($urandom_range(1)));
            if (hw && cw && ha == ca) cw = 0;
            bus(1, hw, ha, $urandom, 1, cw, ca, $urandom);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule